// File: doc/BRIEF.md
# Memory Bandwidth Grant Monitor

This performance monitor sits next to a memory controller arbiter and counts the clock cycles in which the arbiter grants requests from chosen requester ports. It has four monitoring channels. Each channel has a port-select mask and a subport-select mask. A grant counts for a channel only when both masks accept it. Every cycle the arbiter presents a vector of grant strobes, one bit per port, and a small subport index for each port.

Software uses the block in a fixed order. First it programs the masks and the window length in cycles. It then writes the control word with the start bit and the channel enables. It polls the start bit until the hardware clears it. Finally it reads one shared total counter and four per-channel counters, and clears them with a control write. Counters saturate instead of wrapping. They hold their values between windows until a clear.

Top module: `grant_bw_monitor`

## Requirements
- R1: A grant on port i counts for channel c only when bit i of that channel's port mask is set and bit k of its subport mask is set, where k is the subport index of port i on `gnt_sub[i*SUB_IDX_W +: SUB_IDX_W]`.
- R2: Control word fields: bit 31 is start/busy, bit 30 is clear, bits 3:0 are the enables for channels 3..0. A read returns busy in bit 31, the latched enables in bits 3:0, and zeros elsewhere. Bit 30 always reads 0.
- R3: A start write opens a window that samples grants on exactly T clock edges, where T is the timer value and a value of 0 is treated as 1. Bit 31 reads 1 during the window and returns to 0 on its own afterwards.
- R4: Within a window, each enabled channel counter rises by one for each cycle with a qualifying grant for that channel, no matter how many ports qualify. The total counter rises by one for each cycle in which at least one enabled channel qualifies. Disabled channels do not count.
- R5: Outside a window all counters hold. Starting a window without the clear bit adds to the earlier values.
- R6: Each counter stops at all-ones and does not wrap.
- R7: An idle control write with bit 30 set zeroes all five counters. If bit 31 is set in the same write, the new window counts up from zero.
- R8: While a window runs, writes to the masks, the timer and the control word have no effect.
- R9: Word addresses: control 0x20; port masks of channels 0..3 at 0x21, 0x23, 0x25, 0x27; subport masks at 0x22, 0x24, 0x26, 0x28; total counter 0x2A; channel counters 0x2B..0x2E; timer 0x2F. Read data appears one cycle after the address. Unmapped addresses read 0.
- R10: After reset, every register and counter reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Word address for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data for the previous cycle's address |
| gnt_vec | input | NUM_PORTS | Per-port grant strobes for this cycle |
| gnt_sub | input | NUM_PORTS*SUB_IDX_W | Subport index of each port, port i in slice i |

## Verification
Two pairs of events can fall in the same cycle. One is a counter clear and a window start, issued by a single control write. The other is a grant on the last sampled edge of a window, at the same moment the busy bit drops. The bench drives a clear-and-start write after windows that leave counters non-zero. It drives a different grant pattern on every cycle, including the last sampled edge and several cycles after it. It compares each counter with a cycle-by-cycle arithmetic model. A lost first grant, an extra trailing grant, or a count carried across the clear all show up as a mismatch.

// File: rtl/bwmon_pkg.sv
package bwmon_pkg;
  localparam int DATA_W      = 32;
  localparam int NUM_CH      = 4;
  localparam int ADR_CTRL    = 'h20;
  localparam int ADR_PM_BASE = 'h21;
  localparam int ADR_SM_BASE = 'h22;
  localparam int ADR_TOTAL   = 'h2A;
  localparam int ADR_CH_BASE = 'h2B;
  localparam int ADR_TIMER   = 'h2F;
  localparam int BIT_START   = 31;
  localparam int BIT_CLEAR   = 30;
endpackage

// File: rtl/bwmon_sat_counter.sv
module bwmon_sat_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] MAX = {W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (inc && cnt != MAX) cnt <= cnt + 1'b1;
  end

  assert_no_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    (!clr && cnt == MAX) |=> cnt == MAX);
  assert_single_step_R4: assert property (@(posedge clk) disable iff (rst)
    !clr |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1));
  assert_clear_zero_R7: assert property (@(posedge clk) disable iff (rst)
    clr |=> cnt == '0);
endmodule

// File: rtl/bwmon_chan_match.sv
module bwmon_chan_match #(
  parameter int NUM_PORTS = 32,
  parameter int SUB_IDX_W = 4,
  localparam int SUB_N    = 1 << SUB_IDX_W
) (
  input  logic [NUM_PORTS-1:0]           gnt_vec,
  input  logic [NUM_PORTS*SUB_IDX_W-1:0] gnt_sub,
  input  logic [NUM_PORTS-1:0]           port_mask,
  input  logic [SUB_N-1:0]               sub_mask,
  output logic                           hit
);
  logic [NUM_PORTS-1:0] qual;

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
    assign qual[i] = gnt_vec[i] && port_mask[i] &&
                     sub_mask[gnt_sub[i*SUB_IDX_W +: SUB_IDX_W]];
  end

  assign hit = |qual;
endmodule

// File: rtl/bwmon_regs.sv
module bwmon_regs
  import bwmon_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int NUM_PORTS = 32,
  parameter int SUB_N     = 16,
  parameter int TIMER_W   = 32
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [DATA_W-1:0]           wdata,
  output logic [NUM_CH*NUM_PORTS-1:0] port_mask,
  output logic [NUM_CH*SUB_N-1:0]     sub_mask,
  output logic [TIMER_W-1:0]          timer_val,
  output logic [NUM_CH-1:0]           ch_en,
  output logic                        running,
  output logic                        clr
);
  logic [TIMER_W-1:0] remain;
  logic               wr_idle;
  logic               ctrl_wr;
  logic               unused_wdata;

  assign unused_wdata = ^wdata;
  assign wr_idle = wr_en && !running;
  assign ctrl_wr = wr_idle && (addr == ADDR_W'(ADR_CTRL));
  assign clr     = ctrl_wr && wdata[BIT_CLEAR];

  always_ff @(posedge clk) begin
    if (rst) begin
      port_mask <= '0;
      sub_mask  <= '0;
      timer_val <= '0;
    end else if (wr_idle) begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (addr == ADDR_W'(ADR_PM_BASE + 2*c))
          port_mask[c*NUM_PORTS +: NUM_PORTS] <= wdata[NUM_PORTS-1:0];
        if (addr == ADDR_W'(ADR_SM_BASE + 2*c))
          sub_mask[c*SUB_N +: SUB_N] <= wdata[SUB_N-1:0];
      end
      if (addr == ADDR_W'(ADR_TIMER)) timer_val <= wdata[TIMER_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      remain  <= '0;
      ch_en   <= '0;
    end else if (ctrl_wr) begin
      ch_en <= wdata[NUM_CH-1:0];
      if (wdata[BIT_START]) begin
        running <= 1'b1;
        remain  <= (timer_val == '0) ? TIMER_W'(1) : timer_val;
      end
    end else if (running) begin
      if (remain == TIMER_W'(1)) running <= 1'b0;
      remain <= remain - 1'b1;
    end
  end

  assert_frozen_cfg_R8: assert property (@(posedge clk) disable iff (rst)
    running |=> ($stable(port_mask) && $stable(sub_mask) && $stable(timer_val) && $stable(ch_en)));
  assert_self_clear_R3: assert property (@(posedge clk) disable iff (rst)
    (running && remain == TIMER_W'(1)) |=> !running);
  assert_start_busy_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !running && addr == ADDR_W'(ADR_CTRL) && wdata[BIT_START]) |=> running);
endmodule

// File: rtl/grant_bw_monitor.sv
module grant_bw_monitor
  import bwmon_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int NUM_PORTS = 32,
  parameter int SUB_IDX_W = 4,
  parameter int CNT_W     = 32,
  parameter int TIMER_W   = 32
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           reg_wr_en,
  input  logic [ADDR_W-1:0]              reg_addr,
  input  logic [31:0]                    reg_wdata,
  output logic [31:0]                    reg_rdata,
  input  logic [NUM_PORTS-1:0]           gnt_vec,
  input  logic [NUM_PORTS*SUB_IDX_W-1:0] gnt_sub
);
  localparam int SUB_N = 1 << SUB_IDX_W;

  logic [NUM_CH*NUM_PORTS-1:0] port_mask;
  logic [NUM_CH*SUB_N-1:0]     sub_mask;
  logic [TIMER_W-1:0]          timer_val;
  logic [NUM_CH-1:0]           ch_en;
  logic                        running;
  logic                        clr;
  logic [NUM_CH-1:0]           hit;
  logic [NUM_CH-1:0]           ch_inc;
  logic                        tot_inc;
  logic [CNT_W-1:0]            tot_cnt;
  logic [CNT_W-1:0]            ch_cnt [NUM_CH];
  logic [DATA_W-1:0]           rd_next;

  bwmon_regs #(
    .ADDR_W(ADDR_W), .NUM_PORTS(NUM_PORTS), .SUB_N(SUB_N), .TIMER_W(TIMER_W)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(reg_wr_en), .addr(reg_addr), .wdata(reg_wdata),
    .port_mask(port_mask), .sub_mask(sub_mask), .timer_val(timer_val),
    .ch_en(ch_en), .running(running), .clr(clr)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    bwmon_chan_match #(.NUM_PORTS(NUM_PORTS), .SUB_IDX_W(SUB_IDX_W)) u_match (
      .gnt_vec(gnt_vec), .gnt_sub(gnt_sub),
      .port_mask(port_mask[c*NUM_PORTS +: NUM_PORTS]),
      .sub_mask(sub_mask[c*SUB_N +: SUB_N]),
      .hit(hit[c])
    );
    assign ch_inc[c] = running && ch_en[c] && hit[c];
    bwmon_sat_counter #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst(rst), .clr(clr), .inc(ch_inc[c]), .cnt(ch_cnt[c])
    );
  end

  assign tot_inc = running && |(ch_en & hit);

  bwmon_sat_counter #(.W(CNT_W)) u_total (
    .clk(clk), .rst(rst), .clr(clr), .inc(tot_inc), .cnt(tot_cnt)
  );

  always_comb begin
    rd_next = '0;
    if (reg_addr == ADDR_W'(ADR_CTRL)) begin
      rd_next[BIT_START]    = running;
      rd_next[NUM_CH-1:0]   = ch_en;
    end
    if (reg_addr == ADDR_W'(ADR_TOTAL))  rd_next[CNT_W-1:0]   = tot_cnt;
    if (reg_addr == ADDR_W'(ADR_TIMER))  rd_next[TIMER_W-1:0] = timer_val;
    for (int c = 0; c < NUM_CH; c++) begin
      if (reg_addr == ADDR_W'(ADR_PM_BASE + 2*c))
        rd_next[NUM_PORTS-1:0] = port_mask[c*NUM_PORTS +: NUM_PORTS];
      if (reg_addr == ADDR_W'(ADR_SM_BASE + 2*c))
        rd_next[SUB_N-1:0] = sub_mask[c*SUB_N +: SUB_N];
      if (reg_addr == ADDR_W'(ADR_CH_BASE + c))
        rd_next[CNT_W-1:0] = ch_cnt[c];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_next;
  end

  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!running && !clr) |=> $stable(tot_cnt));
  assert_total_follows_R4: assert property (@(posedge clk) disable iff (rst)
    (|ch_inc && !clr && tot_cnt != {CNT_W{1'b1}}) |=> tot_cnt == $past(tot_cnt) + 1'b1);
endmodule

// File: tb/grant_bw_monitor_tb.sv
`timescale 1ns/1ps
module grant_bw_monitor_tb;
  localparam int NP  = 8;
  localparam int SIW = 2;
  localparam int CW  = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr_en = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [NP-1:0]     gnt_vec = '0;
  logic [NP*SIW-1:0] gnt_sub = '0;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [7:0]  pm [4];
  logic [3:0]  sm [4];
  logic [31:0] tmr;
  int exp_tot;
  int exp_ch [4];

  always #2 clk = ~clk;

  grant_bw_monitor #(.ADDR_W(6), .NUM_PORTS(NP), .SUB_IDX_W(SIW), .CNT_W(CW), .TIMER_W(32))
  u_dut (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .gnt_vec(gnt_vec), .gnt_sub(gnt_sub)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic set_ch(input int c, input logic [7:0] p, input logic [3:0] s);
    wr(6'(8'h21 + 2*c), {24'd0, p});
    wr(6'(8'h22 + 2*c), {28'd0, s});
    pm[c] = p; sm[c] = s;
  endtask

  task automatic set_timer(input logic [31:0] t);
    wr(6'h2F, t);
    tmr = t;
  endtask

  function automatic logic [3:0] hits(input logic [7:0] g, input logic [15:0] s);
    logic [3:0] h = '0;
    for (int c = 0; c < 4; c++)
      for (int i = 0; i < NP; i++)
        if (g[i] && pm[c][i] && sm[c][s[2*i +: 2]]) h[c] = 1'b1;
    return h;
  endfunction

  function automatic int sat_inc(input int v);
    return (v >= 255) ? 255 : v + 1;
  endfunction

  // mode 0: hashed pattern, mode 1: all ports granted with subport 0
  task automatic run_window(input logic [3:0] en, input bit clr, input int mode,
                            input int seed, input bit intrude);
    int t_eff;
    logic [3:0] h;
    t_eff = (tmr == 0) ? 1 : int'(tmr);
    if (clr) begin
      exp_tot = 0;
      for (int c = 0; c < 4; c++) exp_ch[c] = 0;
    end
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = 6'h20;
    reg_wdata = 32'h8000_0000 | (32'(clr) << 30) | {28'd0, en};
    @(negedge clk);
    reg_wr_en = 1'b0;
    for (int j = 0; j < t_eff + 5; j++) begin
      if (j == 1) begin
        chk("R2 R3 busy bit during window", {31'd0, reg_rdata[31]}, 32'd1);
        chk("R2 enable readback during window", {28'd0, reg_rdata[3:0]}, {28'd0, en});
      end
      if (mode == 1) begin
        gnt_vec = 8'hFF; gnt_sub = 16'h0000;
      end else begin
        gnt_vec = 8'((j * 29 + seed * 7 + 3) ^ (j >> 1));
        gnt_sub = 16'((j * 40503 + seed * 97 + 5) ^ (j << 3));
      end
      reg_wr_en = 1'b0;
      if (intrude) begin
        if (j == 1) begin reg_wr_en = 1'b1; reg_addr = 6'h21; reg_wdata = 32'h5A; end
        if (j == 2) begin reg_wr_en = 1'b1; reg_addr = 6'h2F; reg_wdata = 32'd3; end
        if (j == 3) begin reg_wr_en = 1'b1; reg_addr = 6'h20; reg_wdata = 32'h4000_0000; end
        if (j == 4) begin reg_wr_en = 1'b1; reg_addr = 6'h24; reg_wdata = 32'h0; end
      end
      if (j < t_eff) begin
        h = hits(gnt_vec, gnt_sub) & en;
        if (h != 0) exp_tot = sat_inc(exp_tot);
        for (int c = 0; c < 4; c++) if (h[c]) exp_ch[c] = sat_inc(exp_ch[c]);
      end
      @(negedge clk);
    end
    reg_wr_en = 1'b0;
    gnt_vec = '0; gnt_sub = '0;
  endtask

  task automatic check_counts(input string tag);
    logic [31:0] d;
    rd(6'h20, d);
    chk({tag, " R3 busy cleared after window"}, {31'd0, d[31]}, 32'd0);
    rd(6'h2A, d);
    chk({tag, " total counter R4"}, d, 32'(exp_tot));
    for (int c = 0; c < 4; c++) begin
      rd(6'(8'h2B + c), d);
      chk({tag, " channel counter R1 R4"}, d, 32'(exp_ch[c]));
    end
  endtask

  initial begin
    logic [31:0] d;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R10: reset state of every mapped word
    for (int a = 'h20; a <= 'h2F; a++) begin
      if (a == 'h29) continue;
      rd(6'(a), d);
      chk("R10 reset value", d, 32'd0);
    end
    // R9: unmapped words read zero
    rd(6'h00, d); chk("R9 unmapped 0x00", d, 32'd0);
    rd(6'h29, d); chk("R9 unmapped 0x29", d, 32'd0);
    rd(6'h3F, d); chk("R9 unmapped 0x3F", d, 32'd0);

    // R9: programming and readback
    set_ch(0, 8'hFF, 4'hF);
    set_ch(1, 8'h33, 4'h5);
    set_ch(2, 8'hC0, 4'h2);
    set_ch(3, 8'h18, 4'hC);
    set_timer(20);
    for (int c = 0; c < 4; c++) begin
      rd(6'(8'h21 + 2*c), d); chk("R9 port mask readback", d, {24'd0, pm[c]});
      rd(6'(8'h22 + 2*c), d); chk("R9 subport mask readback", d, {28'd0, sm[c]});
    end
    rd(6'h2F, d); chk("R9 timer readback", d, 32'd20);

    // R1 R3 R4 R7: clear-and-start window
    run_window(4'hF, 1'b1, 0, 1, 1'b0);
    check_counts("win1");

    // R5: idle hold, then accumulate without clear, two channels disabled
    set_timer(15);
    check_counts("idle hold R5");
    run_window(4'h5, 1'b0, 0, 2, 1'b0);
    check_counts("accumulate R5");

    // R1: sweep of every subport mask value on channel 0
    set_timer(12);
    for (int v = 0; v < 16; v++) begin
      set_ch(0, 8'hFF, 4'(v));
      set_ch(1, 8'(8'hA5 ^ v), 4'(~v));
      run_window(4'hF, 1'b1, 0, 10 + v, 1'b0);
      check_counts("subport sweep R1");
    end

    // R7: standalone clear
    wr(6'h20, 32'h4000_000F);
    exp_tot = 0;
    for (int c = 0; c < 4; c++) exp_ch[c] = 0;
    check_counts("clear R7");

    // R3: timer 0 behaves as one cycle
    set_ch(0, 8'hFF, 4'hF);
    set_timer(0);
    run_window(4'hF, 1'b1, 1, 0, 1'b0);
    check_counts("timer zero R3");
    chk("R3 single-cycle window total", 32'(exp_tot), 32'd1);

    // R8: writes during a window are ignored
    set_timer(10);
    run_window(4'hF, 1'b1, 0, 40, 1'b1);
    check_counts("busy writes R8");
    rd(6'h21, d); chk("R8 port mask unchanged", d, {24'd0, pm[0]});
    rd(6'h24, d); chk("R8 subport mask unchanged", d, {28'd0, sm[1]});
    rd(6'h2F, d); chk("R8 timer unchanged", d, 32'd10);

    // R6: saturation
    for (int c = 0; c < 4; c++) set_ch(c, 8'hFF, 4'hF);
    set_timer(300);
    run_window(4'hF, 1'b1, 1, 0, 1'b0);
    check_counts("saturate R6");
    chk("R6 model at all-ones", 32'(exp_tot), 32'd255);
    set_timer(5);
    run_window(4'hF, 1'b0, 1, 0, 1'b0);
    check_counts("no wrap R6");

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R3 actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule